// File: doc/BRIEF.md
# RS-485 Transmit-Direction Controller

This block steers the driver-enable (direction) pin of an RS-485 half-duplex transceiver from the activity of a UART transmitter. When automatic steering is on and routed to the pin, the output goes to its active level in the same cycle that the transmitter reports it is busy. After the transmitter goes idle, the output stays active for a programmed number of whole bit times so that the last stop bit is fully on the wire. It is then released. Nothing is delayed before a transmission starts.

A bit time is measured from the integer part of the UART clock divisor at 16x oversampling. The fractional part of the divisor has no effect. The polarity of the pin can be inverted for transceivers with an active-low enable. When automatic steering is off, the pin simply carries the software RTS level.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: Automatic steering is on only when configuration bit 0 (enable) and bit 1 (route to pin) are both 1. Otherwise `dir_o` equals `sw_rts_i` and `tx_busy_i` has no effect on it.
- R2: In automatic mode, `dir_o` takes its active level combinationally in the same cycle that `tx_busy_i` is 1, and holds it for as long as `tx_busy_i` stays 1.
- R3: Configuration bit 2 selects polarity. When it is 0, the active level is 1 and the inactive level is 0. When it is 1, the active level is 0 and the inactive level is 1.
- R4: Let D be the release delay in configuration bits 11:8 (0 to 15), and let E0 be the first clock edge that samples `tx_busy_i` low after a transmission. `dir_o` stays active through D×B further clock edges, where B is the bit time. It returns to the inactive level at edge E0 + D×B.
- R5: With D = 0, `dir_o` returns to the inactive level at edge E0, the first edge that samples `tx_busy_i` low.
- R6: The bit time B is 16×Q clocks. Q is the divisor word above bit 7. Divisor bits 7:0 (the fraction) are ignored, and Q = 0 is treated as Q = 1.
- R7: If `tx_busy_i` rises again while the release delay is counting, `dir_o` stays active with no inactive cycle. The full delay restarts from the next falling edge of busy.
- R8: While `rst_ni` is low, the delay count is cleared and, in automatic mode, `dir_o` sits at the inactive level given by the polarity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock (the clock the divisor counts) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_word_i | input | 12 | Bit 0 enable, bit 1 route to pin, bit 2 polarity, bits 11:8 release delay in bit times |
| div_word_i | input | DIV_W (16) | Clock divisor: integer quotient in bits DIV_W-1:8, fraction in 7:0 |
| tx_busy_i | input | 1 | High while the UART transmitter is sending, including the stop bit |
| sw_rts_i | input | 1 | Software-controlled RTS level |
| dir_o | output | 1 | Transceiver direction / RTS pin |

## Verification
Four properties hold on every cycle: the active level while busy, the cycle right after busy falls staying active, an immediate release for a zero delay, and the rule that a release never follows a busy cycle. These are all checked against the polarity bit. The exact release cycle for nonzero delays depends on the product of the delay and the divisor, so only the bench's timed scenarios show it. The same goes for the clamping of a zero quotient, the ignored fraction, the restart after a renewed busy, and the manual RTS pass-through.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;
    localparam int CFG_W      = 12;
    localparam int EN_BIT     = 0;
    localparam int ROUTE_BIT  = 1;
    localparam int POL_BIT    = 2;
    localparam int DLY_LSB    = 8;
    localparam int DLY_W      = 4;
    localparam int FRAC_W     = 8;
    localparam int OVS_LOG2   = 4;

    typedef enum logic [1:0] {
        DIR_IDLE = 2'd0,
        DIR_SEND = 2'd1,
        DIR_HOLD = 2'd2
    } dir_state_e;

    typedef struct packed {
        logic             auto_on;
        logic             invert;
        logic [DLY_W-1:0] delay;
    } dir_cfg_t;
endpackage

// File: rtl/rs485_cfg_decode.sv
module rs485_cfg_decode
    import rs485_dir_pkg::*;
#(
    parameter int DIV_W  = 16,
    localparam int QUOT_W = DIV_W - FRAC_W
) (
    input  logic [CFG_W-1:0]  cfg_word_i,
    input  logic [DIV_W-1:0]  div_word_i,
    output dir_cfg_t          cfg_o,
    output logic [QUOT_W-1:0] quot_o
);
    logic [QUOT_W-1:0] raw_quot;
    logic              unused_bits;

    assign raw_quot = div_word_i[DIV_W-1:FRAC_W];
    assign unused_bits = ^{div_word_i[FRAC_W-1:0], cfg_word_i[DLY_LSB-1:POL_BIT+1]};

    always_comb begin
        cfg_o.auto_on = cfg_word_i[EN_BIT] & cfg_word_i[ROUTE_BIT];
        cfg_o.invert  = cfg_word_i[POL_BIT];
        cfg_o.delay   = cfg_word_i[DLY_LSB +: DLY_W];
        quot_o        = (raw_quot == '0) ? QUOT_W'(1) : raw_quot;
    end
endmodule

// File: rtl/rs485_bit_timer.sv
module rs485_bit_timer
    import rs485_dir_pkg::*;
#(
    parameter int QUOT_W = 8,
    localparam int CNT_W = QUOT_W + OVS_LOG2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic [QUOT_W-1:0] quot_i,
    output logic              tick_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t             tmr_d, tmr_q;
    logic [CNT_W-1:0] last;

    assign last   = {quot_i, {OVS_LOG2{1'b0}}} - CNT_W'(1);
    assign tick_o = run_i && (tmr_q.cnt == last);

    always_comb begin
        tmr_d = tmr_q;
        if (!run_i || tick_o) begin
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end
endmodule

// File: rtl/rs485_dir_fsm.sv
module rs485_dir_fsm
    import rs485_dir_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             auto_i,
    input  logic             busy_i,
    input  logic             tick_i,
    input  logic [DLY_W-1:0] delay_i,
    output logic             run_o,
    output logic             active_o
);
    typedef struct packed {
        dir_state_e       state;
        logic [DLY_W-1:0] bits;
    } fsm_t;

    fsm_t           fsm_d, fsm_q;
    logic [DLY_W:0] bits_next;

    assign bits_next = {1'b0, fsm_q.bits} + (DLY_W+1)'(1);

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.state)
            DIR_IDLE: begin
                if (busy_i) fsm_d.state = DIR_SEND;
            end
            DIR_SEND: begin
                fsm_d.bits = '0;
                if (!busy_i) begin
                    fsm_d.state = (delay_i == '0) ? DIR_IDLE : DIR_HOLD;
                end
            end
            DIR_HOLD: begin
                if (busy_i) begin
                    fsm_d.state = DIR_SEND;
                    fsm_d.bits  = '0;
                end else if (delay_i == '0) begin
                    fsm_d.state = DIR_IDLE;
                end else if (tick_i) begin
                    if (bits_next >= {1'b0, delay_i}) begin
                        fsm_d.state = DIR_IDLE;
                        fsm_d.bits  = '0;
                    end else begin
                        fsm_d.bits = bits_next[DLY_W-1:0];
                    end
                end
            end
            default: fsm_d.state = DIR_IDLE;
        endcase
        if (!auto_i) begin
            fsm_d.state = DIR_IDLE;
            fsm_d.bits  = '0;
        end
    end

    assign run_o    = (fsm_q.state == DIR_HOLD) && !busy_i;
    assign active_o = busy_i || (fsm_q.state != DIR_IDLE);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fsm_q <= '{state: DIR_IDLE, bits: '0};
        end else begin
            fsm_q <= fsm_d;
        end
    end
endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
    import rs485_dir_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CFG_W-1:0] cfg_word_i,
    input  logic [DIV_W-1:0] div_word_i,
    input  logic             tx_busy_i,
    input  logic             sw_rts_i,
    output logic             dir_o
);
    localparam int QUOT_W = DIV_W - FRAC_W;

    dir_cfg_t          cfg;
    logic [QUOT_W-1:0] quot;
    logic              run;
    logic              tick;
    logic              active;

    rs485_cfg_decode #(.DIV_W(DIV_W)) u_decode (
        .cfg_word_i (cfg_word_i),
        .div_word_i (div_word_i),
        .cfg_o      (cfg),
        .quot_o     (quot)
    );

    rs485_bit_timer #(.QUOT_W(QUOT_W)) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (run),
        .quot_i (quot),
        .tick_o (tick)
    );

    rs485_dir_fsm u_fsm (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .auto_i   (cfg.auto_on),
        .busy_i   (tx_busy_i),
        .tick_i   (tick),
        .delay_i  (cfg.delay),
        .run_o    (run),
        .active_o (active)
    );

    assign dir_o = cfg.auto_on ? (active ^ cfg.invert) : sw_rts_i;
endmodule

// File: rtl/rs485_dir_ctrl_chk.sv
module rs485_dir_ctrl_chk
    import rs485_dir_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic [CFG_W-1:0] cfg_word_i,
    input logic             tx_busy_i,
    input logic             dir_o
);
    logic             auto_on;
    logic             pol;
    logic [DLY_W-1:0] dly;

    assign auto_on = cfg_word_i[EN_BIT] & cfg_word_i[ROUTE_BIT];
    assign pol     = cfg_word_i[POL_BIT];
    assign dly     = cfg_word_i[DLY_LSB +: DLY_W];

    p_send_level_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (auto_on && tx_busy_i) |-> (dir_o == !pol));

    p_hold_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (auto_on && $past(auto_on) && $stable(cfg_word_i) && $past(tx_busy_i) && !tx_busy_i)
        |-> (dir_o == !pol));

    p_zero_delay_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (auto_on && $stable(cfg_word_i) && dly == '0 && !tx_busy_i && !$past(tx_busy_i))
        |-> (dir_o == pol));

    p_release_after_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (auto_on && $past(auto_on) && $stable(cfg_word_i) && dir_o == pol && $past(dir_o) != dir_o)
        |-> !$past(tx_busy_i));
endmodule

bind rs485_dir_ctrl rs485_dir_ctrl_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_word_i (cfg_word_i),
    .tx_busy_i  (tx_busy_i),
    .dir_o      (dir_o)
);

// File: tb/test_rs485_dir_ctrl.sv
module test_rs485_dir_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 16;

    typedef struct {
        int    cyc;
        logic  val;
        string tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [11:0]      cfg = '0;
    logic [DIV_W-1:0] div = '0;
    logic             busy = 1'b0;
    logic             sw_rts = 1'b0;
    logic             dir;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    exp_t sb[$];

    rs485_dir_ctrl #(.DIV_W(DIV_W)) i_rs485_dir_ctrl (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .cfg_word_i (cfg),
        .div_word_i (div),
        .tx_busy_i  (busy),
        .sw_rts_i   (sw_rts),
        .dir_o      (dir)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cyc=%0d actual=%b expected=%b", tag, cyc, act, exp);
        end
    endtask

    // monitor: compares queued expectations at the falling edge of their cycle
    initial begin
        forever begin
            @(negedge clk);
            for (int i = sb.size() - 1; i >= 0; i--) begin
                if (sb[i].cyc <= cyc) begin
                    check(dir, sb[i].val, sb[i].tag);
                    sb.delete(i);
                end
            end
        end
    end

    task automatic push(input int c, input logic v, input string tag);
        exp_t e;
        e.cyc = c; e.val = v; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk); #1;
    endtask

    task automatic set_cfg(input logic en, input logic route, input logic pol, input int dly);
        cfg = '0;
        cfg[0] = en; cfg[1] = route; cfg[2] = pol;
        cfg[11:8] = 4'(dly);
    endtask

    // frame: busy for len cycles, then expect release after dly*bclk edges
    task automatic frame(input int len, input int dly, input int bclk, input logic act, input string tag);
        int c;
        @(negedge clk); #1;
        busy = 1'b1;
        #1 check(dir, act, "R2 busy rise");
        push(cyc + 1, act, "R2 busy held");
        repeat (len) @(negedge clk);
        #1;
        c = cyc;
        busy = 1'b0;
        if (dly > 0) push(c + dly*bclk, act, {tag, " last active"});
        push(c + dly*bclk + 1, !act, {tag, " released"});
        drain();
    endtask

    initial begin
        int c;
        div = 16'h0100;
        set_cfg(1, 1, 0, 0);
        sw_rts = 1'b1;
        repeat (3) @(negedge clk);
        #1 check(dir, 1'b0, "R8 reset inactive pol0");
        set_cfg(1, 1, 1, 0);
        #1 check(dir, 1'b1, "R8 R3 reset inactive pol1");
        set_cfg(1, 1, 0, 0);
        @(negedge clk); #1;
        rst_n = 1'b1;

        // R5 zero delay
        frame(4, 0, 16, 1'b1, "R5");
        // R4 delay 3, Q=1
        set_cfg(1, 1, 0, 3);
        frame(5, 3, 16, 1'b1, "R4");
        // R3 inverted polarity
        set_cfg(1, 1, 1, 2);
        @(negedge clk); #1 check(dir, 1'b1, "R3 idle level inverted");
        frame(3, 2, 16, 1'b0, "R3");
        // R4 maximum delay, Q=2
        set_cfg(1, 1, 0, 15);
        div = 16'h0200;
        frame(2, 15, 32, 1'b1, "R4 max");
        // R6 fraction ignored
        div = 16'h01FF;
        set_cfg(1, 1, 0, 2);
        frame(2, 2, 16, 1'b1, "R6 frac");
        // R6 zero quotient clamps to one
        div = 16'h0080;
        set_cfg(1, 1, 0, 1);
        frame(2, 1, 16, 1'b1, "R6 q0");

        // R7 busy again during hold
        div = 16'h0100;
        set_cfg(1, 1, 0, 3);
        @(negedge clk); #1;
        busy = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        c = cyc;
        busy = 1'b0;
        for (int k = 1; k <= 10; k++) push(c + k, 1'b1, "R7 holding");
        repeat (10) @(negedge clk);
        #1 busy = 1'b1;
        #1 check(dir, 1'b1, "R7 no glitch");
        for (int k = 1; k <= 5; k++) push(cyc + k, 1'b1, "R7 resend");
        repeat (5) @(negedge clk);
        #1;
        c = cyc;
        busy = 1'b0;
        push(c + 47, 1'b1, "R7 restarted hold");
        push(c + 48, 1'b1, "R7 full delay");
        push(c + 49, 1'b0, "R7 released");
        drain();

        // R1 manual mode: enable off, then route off
        set_cfg(0, 1, 0, 3);
        busy = 1'b1; sw_rts = 1'b0;
        #1 check(dir, 1'b0, "R1 en off sw0");
        sw_rts = 1'b1;
        #1 check(dir, 1'b1, "R1 en off sw1");
        set_cfg(1, 0, 1, 3);
        sw_rts = 1'b0;
        @(negedge clk); #1 check(dir, 1'b0, "R1 route off busy ignored");
        busy = 1'b0;
        repeat (2) @(negedge clk);
        #1 check(dir, 1'b0, "R1 route off idle");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired cyc=%0d actual=running expected=done", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule